// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a serial memory front end. It gathers the data bytes of a page write, for either the main array or the identification page, into a one-page staging buffer. The first byte lands at the offset given by the low address bits of the start address. Each later byte goes to the next offset. The offset wraps inside the same page, so that when more bytes arrive than a page holds, the last ones overwrite the first.

When chip select is released, the block checks whether the write is allowed, using the write-enable latch, the block-protection setting and the identification-page lock. If the write is allowed, the block raises `busy` for a programmable number of clock cycles. It then drains only the offsets that actually received a byte to the array or identification-page write port, one per cycle in ascending offset order. At the end it pulses `done`, and a neighbouring protection block uses that pulse to clear its write-enable latch.

An identification-page command with address bit 10 set is the lock command. It commits nothing to the page. Instead it raises `lockSet` once, and only after strict framing checks pass. The serial shifting is done outside the block. The front end only reports complete bytes, a flag for a byte left unfinished, and the chip-select rise.

Top module: `page_write_engine`

## Requirements
- R1: After reset `busy`, `done`, `memWrEn`, `idWrEn` and `lockSet` are all 0.
- R2: The first data byte is placed at offset `startAddr[5:0]` and each following byte at the next offset. After offset 63 the next byte goes to offset 0. Every array write address is `{startAddr[14:6], offset}`.
- R3: When more than 64 bytes are sent, each offset holds the last byte sent to it.
- R4: Only offsets that received a complete byte produce a write strobe. A byte still unfinished when chip select rises (`bitsPending`=1) is dropped, and it does not stop an array or identification-page write.
- R5: An allowed array or identification-page commit holds `busy`=1 from the cycle after `csRise` for WR_CYCLES+64 cycles. Its write strobes occur only in the last 64 of those cycles, in ascending offset order, one offset per cycle.
- R6: `done` is high for exactly one cycle, the cycle right after `busy` falls at the end of a commit, and `busy` is 0 in that cycle.
- R7: An array write is allowed only if `writeEnable`=1 and at least one byte was received. It is refused if `blkProt`=3, if `blkProt`=2 and `startAddr[14]`=1, or if `blkProt`=1 and `startAddr[14:13]`=3. A refused write gives no `busy`, no writes and no `done`.
- R8: With `cmdIsId`=1 and `startAddr[10]`=0, bytes go to the identification port at offset `idWrAddr`. The write is refused when `idLocked`=1 or `writeEnable`=0.
- R9: With `cmdIsId`=1 and `startAddr[10]`=1, the lock executes only if all of the following hold: exactly one complete byte was sent, that byte has bit 1 set, `bitsPending`=0, `writeEnable`=1, `blkProt`≠3 and `idLocked`=0. When it executes, `busy` lasts WR_CYCLES+1 cycles, `lockSet` pulses in the last of them, and no page write occurs.
- R10: While `busy`=1, `cmdStart`, `byteValid` and `csRise` are ignored and do not change the data committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | Pulse: address phase complete, start a new collection |
| cmdIsId | input | 1 | 1 = identification-page command, 0 = array write |
| startAddr | input | ADDR_W | Start address; bit 10 selects lock for identification commands |
| byteValid | input | 1 | Pulse: one complete data byte on byteData |
| byteData | input | 8 | Received data byte |
| bitsPending | input | 1 | Some bits of an unfinished byte were received |
| csRise | input | 1 | Pulse: chip select released |
| writeEnable | input | 1 | Write-enable latch state |
| blkProt | input | 2 | Block-protection level |
| idLocked | input | 1 | Identification page already locked |
| busy | output | 1 | Self-timed write in progress |
| done | output | 1 | One-cycle completion pulse |
| memWrEn | output | 1 | Array write strobe |
| memWrAddr | output | ADDR_W | Array write address |
| memWrData | output | 8 | Array write data |
| idWrEn | output | 1 | Identification-page write strobe |
| idWrAddr | output | 6 | Identification-page offset |
| idWrData | output | 8 | Identification-page write data |
| lockSet | output | 1 | One-cycle pulse that sets the page lock |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- Offset wrap at 63. A design that carried into the page bits would write outside the page.
- A 70-byte stream. A design that kept the first 64 bytes, rather than the last, would commit stale data.
- A partial page ending in an unfinished byte. A design that wrote the whole page would emit strobes for offsets that received nothing.
- Each protection level, and every refusal reason for the lock command. Getting any of these wrong shows up as a spurious `busy` or `lockSet`.
- Traffic sent during `busy`. A design that accepted it would change the drained data or restart the timer.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

  typedef enum logic [1:0] {
    KIND_ARRAY = 2'd0,
    KIND_ID    = 2'd1,
    KIND_LOCK  = 2'd2
  } wrKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;     // latch start address, clear the valid mask
    logic take;      // store one data byte at the running offset
    logic drainClr;  // rewind the drain index
    logic drainAdv;  // step the drain index
  } dpCtl_t;

endpackage

// File: rtl/pwe_datapath.sv
module pwe_datapath
  import pwe_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int PAGE_BITS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  dpCtl_t                      ctl,
  input  logic [ADDR_W-1:0]           startAddr,
  input  logic [7:0]                  byteData,
  output logic [ADDR_W-PAGE_BITS-1:0] pageBase,
  output logic [PAGE_BITS-1:0]        drainIdx,
  output logic                        slotValid,
  output logic [7:0]                  slotData,
  output logic                        anyByte,
  output logic                        multiByte,
  output logic                        lockKey
);
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int PAGE_W     = ADDR_W - PAGE_BITS;

  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slotMask;
  logic [PAGE_BITS-1:0]  offset;

  always_ff @(posedge clk) begin
    if (ctl.take) pageBuf[offset] <= byteData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotMask  <= '0;
      offset    <= '0;
      pageBase  <= '0;
      anyByte   <= 1'b0;
      multiByte <= 1'b0;
      lockKey   <= 1'b0;
    end else if (ctl.start) begin
      slotMask  <= '0;
      offset    <= startAddr[PAGE_BITS-1:0];
      pageBase  <= startAddr[ADDR_W-1:PAGE_BITS];
      anyByte   <= 1'b0;
      multiByte <= 1'b0;
    end else if (ctl.take) begin
      slotMask[offset] <= 1'b1;
      offset           <= offset + 1'b1;   // wraps inside the page
      multiByte        <= anyByte;
      anyByte          <= 1'b1;
      lockKey          <= byteData[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            drainIdx <= '0;
    else if (ctl.drainClr) drainIdx <= '0;
    else if (ctl.drainAdv) drainIdx <= drainIdx + 1'b1;
  end

  assign slotValid = slotMask[drainIdx];
  assign slotData  = pageBuf[drainIdx];

  // R2: the offset following the last slot of the page is slot 0
  assert_offset_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.take && !ctl.start && offset == PAGE_BITS'(PAGE_BYTES-1)) |=> offset == '0);

  // R2: page bits never move while bytes stream in
  assert_page_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.take && !ctl.start) |=> $stable(pageBase));

  logic unusedW;
  assign unusedW = ^PAGE_W;
endmodule

// File: rtl/pwe_control.sv
module pwe_control
  import pwe_pkg::*;
#(
  parameter int PAGE_BITS = 6,
  parameter int WR_CYCLES = 100000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdStart,
  input  logic                 cmdIsId,
  input  logic                 lockSel,
  input  logic                 byteValid,
  input  logic                 bitsPending,
  input  logic                 csRise,
  input  logic                 writeEnable,
  input  logic [1:0]           blkProt,
  input  logic                 idLocked,
  input  logic [1:0]           pageTop,
  input  logic                 anyByte,
  input  logic                 multiByte,
  input  logic                 lockKey,
  input  logic [PAGE_BITS-1:0] drainIdx,
  output dpCtl_t               ctl,
  output logic                 busy,
  output logic                 done,
  output logic                 drainActive,
  output wrKind_t              kind
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_TIMING, ST_DRAIN} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             grant;
  logic             arrProt;
  logic             canStart;
  logic             timerEnd;
  logic             drainEnd;

  always_comb begin
    unique case (blkProt)
      2'd0:    arrProt = 1'b0;
      2'd1:    arrProt = (pageTop == 2'b11);
      2'd2:    arrProt = pageTop[1];
      default: arrProt = 1'b1;
    endcase
    grant = 1'b0;
    if (writeEnable && anyByte) begin
      unique case (kind)
        KIND_ARRAY: grant = !arrProt;
        KIND_ID:    grant = !idLocked;
        default:    grant = !idLocked && !multiByte && !bitsPending &&
                            lockKey && (blkProt != 2'd3);
      endcase
    end
  end

  assign canStart = cmdStart && (state == ST_IDLE || state == ST_COLLECT);
  assign timerEnd = (state == ST_TIMING) && (cnt == CNT_W'(1));
  assign drainEnd = (state == ST_DRAIN) &&
                    (kind == KIND_LOCK || drainIdx == {PAGE_BITS{1'b1}});

  always_comb begin
    ctl          = '0;
    ctl.start    = canStart;
    ctl.take     = (state == ST_COLLECT) && byteValid && !csRise && !cmdStart;
    ctl.drainClr = timerEnd;
    ctl.drainAdv = (state == ST_DRAIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      kind  <= KIND_ARRAY;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (canStart) begin
        state <= ST_COLLECT;
        kind  <= !cmdIsId ? KIND_ARRAY : (lockSel ? KIND_LOCK : KIND_ID);
      end else begin
        unique case (state)
          ST_COLLECT: if (csRise) begin
            if (grant) begin
              state <= ST_TIMING;
              cnt   <= CNT_W'(WR_CYCLES);
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_TIMING: begin
            cnt <= cnt - 1'b1;
            if (timerEnd) state <= ST_DRAIN;
          end
          ST_DRAIN: if (drainEnd) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy        = (state == ST_TIMING) || (state == ST_DRAIN);
  assign drainActive = (state == ST_DRAIN);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_from_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(csRise));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmdStart) |=> !ctl.start || busy);
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import pwe_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int PAGE_BITS = 6,
  parameter int LOCK_BIT  = 10,
  parameter int WR_CYCLES = 100000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdStart,
  input  logic                 cmdIsId,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic                 byteValid,
  input  logic [7:0]           byteData,
  input  logic                 bitsPending,
  input  logic                 csRise,
  input  logic                 writeEnable,
  input  logic [1:0]           blkProt,
  input  logic                 idLocked,
  output logic                 busy,
  output logic                 done,
  output logic                 memWrEn,
  output logic [ADDR_W-1:0]    memWrAddr,
  output logic [7:0]           memWrData,
  output logic                 idWrEn,
  output logic [PAGE_BITS-1:0] idWrAddr,
  output logic [7:0]           idWrData,
  output logic                 lockSet
);
  localparam int PAGE_W = ADDR_W - PAGE_BITS;

  dpCtl_t               ctl;
  wrKind_t              kind;
  logic [PAGE_W-1:0]    pageBase;
  logic [PAGE_BITS-1:0] drainIdx;
  logic                 slotValid, anyByte, multiByte, lockKey, drainActive;
  logic [7:0]           slotData;

  pwe_datapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .startAddr(startAddr),
    .byteData(byteData), .pageBase(pageBase), .drainIdx(drainIdx),
    .slotValid(slotValid), .slotData(slotData), .anyByte(anyByte),
    .multiByte(multiByte), .lockKey(lockKey)
  );

  pwe_control #(.PAGE_BITS(PAGE_BITS), .WR_CYCLES(WR_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdIsId(cmdIsId),
    .lockSel(startAddr[LOCK_BIT]), .byteValid(byteValid),
    .bitsPending(bitsPending), .csRise(csRise), .writeEnable(writeEnable),
    .blkProt(blkProt), .idLocked(idLocked), .pageTop(pageBase[PAGE_W-1 -: 2]),
    .anyByte(anyByte), .multiByte(multiByte), .lockKey(lockKey),
    .drainIdx(drainIdx), .ctl(ctl), .busy(busy), .done(done),
    .drainActive(drainActive), .kind(kind)
  );

  assign memWrEn   = drainActive && (kind == KIND_ARRAY) && slotValid;
  assign memWrAddr = {pageBase, drainIdx};
  assign memWrData = slotData;
  assign idWrEn    = drainActive && (kind == KIND_ID) && slotValid;
  assign idWrAddr  = drainIdx;
  assign idWrData  = slotData;
  assign lockSet   = drainActive && (kind == KIND_LOCK);

  assert_write_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrEn || idWrEn || lockSet) |-> busy);

  assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({memWrEn, idWrEn, lockSet}));

  assert_lock_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lockSet |=> !lockSet);

  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrEn && $past(memWrEn)) |-> memWrAddr == $past(memWrAddr) + 1'b1);
endmodule

// File: tb/tb_page_write_engine.sv
module tb_page_write_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WR  = 12;
  localparam int AW  = 15;

  logic clk = 0, rst_n = 0;
  logic cmdStart = 0, cmdIsId = 0, byteValid = 0, bitsPending = 0, csRise = 0;
  logic [AW-1:0] startAddr = '0;
  logic [7:0] byteData = '0;
  logic writeEnable = 0, idLocked = 0;
  logic [1:0] blkProt = 0;
  logic busy, done, memWrEn, idWrEn, lockSet;
  logic [AW-1:0] memWrAddr;
  logic [7:0] memWrData, idWrData;
  logic [5:0] idWrAddr;

  page_write_engine #(.WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdIsId(cmdIsId),
    .startAddr(startAddr), .byteValid(byteValid), .byteData(byteData),
    .bitsPending(bitsPending), .csRise(csRise), .writeEnable(writeEnable),
    .blkProt(blkProt), .idLocked(idLocked), .busy(busy), .done(done),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .idWrEn(idWrEn), .idWrAddr(idWrAddr), .idWrData(idWrData), .lockSet(lockSet)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  string curReq = "R1";

  // behavioural model: 0 array, 1 id page, 2 lock
  int  mKind, mOff, mPage, mCount, mLast;
  bit  mCollect = 0, active = 0;
  int  mBuf[64];
  int  expWr[64];
  int  eKind, ePage, busyEnd;
  int  tl = 0;

  task automatic fail(string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
  endtask

  always @(negedge clk) if (rst_n) begin
    bit eBusy, eDone, eMem, eId, eLock;
    int idx;
    if (active) tl++;
    eBusy = active && tl >= 1 && tl <= busyEnd;
    eDone = active && tl == busyEnd + 1;
    idx   = tl - WR - 1;
    eMem  = active && eKind == 0 && idx >= 0 && idx < 64 && expWr[idx] >= 0;
    eId   = active && eKind == 1 && idx >= 0 && idx < 64 && expWr[idx] >= 0;
    eLock = active && eKind == 2 && idx == 0;
    vectors++;
    if (busy !== eBusy)   fail("busy", busy, eBusy);
    if (done !== eDone)   fail("done", done, eDone);
    if (lockSet !== eLock) fail("lockSet", lockSet, eLock);
    if (memWrEn !== eMem) fail("memWrEn", memWrEn, eMem);
    else if (eMem) begin
      if (memWrAddr !== AW'((ePage << 6) | idx)) fail("memWrAddr", memWrAddr, (ePage << 6) | idx);
      if (memWrData !== 8'(expWr[idx]))          fail("memWrData", memWrData, expWr[idx]);
    end
    if (idWrEn !== eId) fail("idWrEn", idWrEn, eId);
    else if (eId) begin
      if (idWrAddr !== 6'(idx))          fail("idWrAddr", idWrAddr, idx);
      if (idWrData !== 8'(expWr[idx]))   fail("idWrData", idWrData, expWr[idx]);
    end
    if (eDone) active = 0;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic beginCmd(bit isId, int addr);
    step();
    cmdStart = 1; cmdIsId = isId; startAddr = AW'(addr);
    if (!active) begin
      mCollect = 1; mCount = 0;
      mKind = !isId ? 0 : (((addr >> 10) & 1) != 0 ? 2 : 1);
      mOff = addr & 63; mPage = (addr >> 6) & 511;
      for (int i = 0; i < 64; i++) mBuf[i] = -1;
    end
    step();
    cmdStart = 0;
  endtask

  task automatic sendByte(int d);
    byteValid = 1; byteData = 8'(d);
    if (mCollect && !active) begin
      mBuf[mOff] = d & 255; mOff = (mOff + 1) % 64; mCount++; mLast = d & 255;
    end
    step();
    byteValid = 0;
  endtask

  task automatic raiseCs(bit pending);
    bit g, prot;
    bitsPending = pending; csRise = 1;
    if (mCollect && !active) begin
      prot = (blkProt == 3) || (blkProt == 2 && ((mPage >> 8) & 1) != 0) ||
             (blkProt == 1 && ((mPage >> 7) & 3) == 3);
      g = writeEnable && mCount > 0;
      if (mKind == 0) g = g && !prot;
      else if (mKind == 1) g = g && !idLocked;
      else g = g && !idLocked && mCount == 1 && !pending && ((mLast >> 1) & 1) != 0 && blkProt != 3;
      mCollect = 0;
      if (g) begin
        active = 1; tl = -1; eKind = mKind; ePage = mPage;
        busyEnd = WR + (mKind == 2 ? 1 : 64);
        for (int i = 0; i < 64; i++) expWr[i] = mBuf[i];
      end
    end
    step();
    csRise = 0; bitsPending = 0;
  endtask

  task automatic settle();
    int guard = 0;
    while (active && guard < 1000) begin step(); guard++; end
    repeat (3) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet outputs out of reset
    vectors++;
    if ({busy, done, memWrEn, idWrEn, lockSet} !== 5'b0) fail("reset outputs", {busy, done, memWrEn, idWrEn, lockSet}, 0);
    rst_n = 1;
    repeat (2) step();

    // R2 R5 R6: wrap from offset 52 through 63 back to 3
    curReq = "R2"; writeEnable = 1; blkProt = 0;
    beginCmd(0, 15'h1234);
    for (int i = 0; i < 16; i++) sendByte(8'hA0 + i);
    raiseCs(0); settle();

    // R3: 70 bytes, last one at each offset wins
    curReq = "R3";
    beginCmd(0, 15'h0205);
    for (int i = 0; i < 70; i++) sendByte((i * 7 + 3) & 255);
    raiseCs(0); settle();

    // R4: three bytes then an unfinished one
    curReq = "R4";
    beginCmd(0, 15'h300A);
    for (int i = 0; i < 3; i++) sendByte(8'h5A ^ i);
    raiseCs(1); settle();

    // R7: permission and protection levels
    curReq = "R7";
    writeEnable = 0; beginCmd(0, 15'h0100); sendByte(1); raiseCs(0); settle();
    writeEnable = 1; beginCmd(0, 15'h0100); raiseCs(0); settle();
    blkProt = 1; beginCmd(0, 15'h7000); sendByte(2); raiseCs(0); settle();
    blkProt = 1; beginCmd(0, 15'h4000); sendByte(3); sendByte(4); raiseCs(0); settle();
    blkProt = 2; beginCmd(0, 15'h4000); sendByte(5); raiseCs(0); settle();
    blkProt = 2; beginCmd(0, 15'h2040); sendByte(6); raiseCs(0); settle();
    blkProt = 3; beginCmd(0, 15'h0040); sendByte(7); raiseCs(0); settle();
    blkProt = 0;

    // R8: identification page write, wrapping, then locked refusal
    curReq = "R8";
    beginCmd(1, 15'h003C);
    for (int i = 0; i < 6; i++) sendByte(8'hC0 + i);
    raiseCs(0); settle();
    idLocked = 1; beginCmd(1, 15'h0001); sendByte(9); raiseCs(0); settle();
    idLocked = 0;
    writeEnable = 0; beginCmd(1, 15'h0001); sendByte(9); raiseCs(0); settle();
    writeEnable = 1;

    // R9: lock command framing
    curReq = "R9";
    beginCmd(1, 15'h0400); sendByte(8'h02); raiseCs(0); settle();
    beginCmd(1, 15'h0400); sendByte(8'hFD); raiseCs(0); settle();
    beginCmd(1, 15'h0400); sendByte(8'h02); sendByte(8'h02); raiseCs(0); settle();
    beginCmd(1, 15'h0400); sendByte(8'h02); raiseCs(1); settle();
    blkProt = 3; beginCmd(1, 15'h0400); sendByte(8'h02); raiseCs(0); settle();
    blkProt = 0;
    idLocked = 1; beginCmd(1, 15'h0400); sendByte(8'h02); raiseCs(0); settle();
    idLocked = 0;
    writeEnable = 0; beginCmd(1, 15'h0400); sendByte(8'h02); raiseCs(0); settle();
    writeEnable = 1;

    // R10: traffic during busy is ignored
    curReq = "R10";
    beginCmd(0, 15'h0810);
    sendByte(8'h11); sendByte(8'h22);
    raiseCs(0);
    beginCmd(0, 15'h0810);
    sendByte(8'h99); sendByte(8'h98);
    raiseCs(0);
    settle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule